// File: doc/BRIEF.md
# Dual-Write General-Purpose Register File

This block is a general-purpose register file with two combinational read ports and two independent synchronous write ports. The main write port (port A) is unchanged in role. A second write port (port B) has its own address, data and enable. A post-incrementing load can therefore commit two results on one clock edge: the loaded word through port A into the destination register, and the incremented base address through port B into the base register.

The two read ports usually take the source and target register fields of an instruction, bits [25:21] and [20:16]. Register 0 is hard-wired to zero. When both ports aim at the same register in one cycle, port A (the loaded data) wins. A read returns the stored value before the edge, so a register being written shows its new value only after the clock edge. An active-low asynchronous reset clears every register.

Top module: `dual_wr_regfile`

## Requirements
- R1: Register 0 always reads as zero on both read ports. A write to address 0 from either port has no effect.
- R2: While rst_ni is low, every register is cleared to zero. After reset, every address reads zero until it is written.
- R3: When wr_en_a_i is high at a rising clock edge and wr_addr_a_i is nonzero, that register holds wr_data_a_i from that edge on.
- R4: When wr_en_b_i is high at a rising clock edge and wr_addr_b_i is nonzero, that register holds wr_data_b_i from that edge on, provided port A does not write the same address in that cycle.
- R5: When both enables are high and the two nonzero addresses differ, both registers are updated on the same clock edge.
- R6: When both enables are high and both addresses are the same nonzero value, that register takes wr_data_a_i. Port B's data is discarded.
- R7: Reads are combinational. During a cycle in which a register is being written, a read of it returns the old value. The new value appears after the clock edge.
- R8: The two read ports are independent. Each returns the content of its own address, including when both addresses are the same.
- R9: A write port whose enable is low changes no register, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | 5 | Read port A address |
| rd_data_a_o | output | 32 | Read port A data (combinational) |
| rd_addr_b_i | input | 5 | Read port B address |
| rd_data_b_o | output | 32 | Read port B data (combinational) |
| wr_en_a_i | input | 1 | Write port A enable (priority port) |
| wr_addr_a_i | input | 5 | Write port A address |
| wr_data_a_i | input | 32 | Write port A data |
| wr_en_b_i | input | 1 | Write port B enable |
| wr_addr_b_i | input | 5 | Write port B address |
| wr_data_b_i | input | 32 | Write port B data |

## Verification
The bench first uses single-port fills through A and then through B, which shows that each port reaches every entry by itself. It then enables both ports at distinct addresses, which separates a true two-register commit from one that drops a port. Next come same-address collisions, writes to register 0 and disabled ports that carry garbage. These tell correct priority, the zero-register rule and enable gating apart from a design that merely stores something. Finally, reads of the register being written in the same cycle, and a long pseudo-random mix with a mid-run reset, show the read-old-value timing and the reset clear.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } wr_src_e;

  function automatic wr_src_e pick_src(input logic hit_a, input logic hit_b);
    if (hit_a)      return SRC_A;
    else if (hit_b) return SRC_B;
    else            return SRC_HOLD;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              en_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic              en_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  output logic [NUM_REGS-1:0] hit_a_o,
  output logic [NUM_REGS-1:0] hit_b_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    if (i == 0) begin : g_zero
      // entry 0 is never written
      assign hit_a_o[i] = 1'b0;
      assign hit_b_o[i] = 1'b0;
    end else begin : g_live
      assign hit_a_o[i] = en_a_i && (addr_a_i == ADDR_W'(i));
      assign hit_b_o[i] = en_b_i && (addr_b_i == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/rf_entry.sv
module rf_entry
  import dwrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_a_i,
  input  logic              hit_b_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  output logic [DATA_W-1:0] q_o
);
  wr_src_e     src;
  logic [DATA_W-1:0] q_d;

  always_comb begin
    src = pick_src(hit_a_i, hit_b_i);
    unique case (src)
      SRC_A:   q_d = data_a_i;
      SRC_B:   q_d = data_b_i;
      default: q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [DATA_W-1:0]               data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr_i == ADDR_W'(k)) data_o = regs_i[k];
    end
  end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  input  logic              wr_en_a_i,
  input  logic [ADDR_W-1:0] wr_addr_a_i,
  input  logic [DATA_W-1:0] wr_data_a_i,
  input  logic              wr_en_b_i,
  input  logic [ADDR_W-1:0] wr_addr_b_i,
  input  logic [DATA_W-1:0] wr_data_b_i
);
  logic [NUM_REGS-1:0]             hit_a, hit_b;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  rf_wr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .en_a_i  (wr_en_a_i),
    .addr_a_i(wr_addr_a_i),
    .en_b_i  (wr_en_b_i),
    .addr_b_i(wr_addr_b_i),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      logic unused_hit;
      assign unused_hit = hit_a[i] | hit_b[i];
      assign regs[i]    = '0;
    end else begin : g_flop
      rf_entry #(.DATA_W(DATA_W)) u_entry (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_a_i (hit_a[i]),
        .hit_b_i (hit_b[i]),
        .data_a_i(wr_data_a_i),
        .data_b_i(wr_data_b_i),
        .q_o     (regs[i])
      );
    end
  end

  rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .regs_i(regs),
    .addr_i(rd_addr_a_i),
    .data_o(rd_data_a_o)
  );

  rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .regs_i(regs),
    .addr_i(rd_addr_b_i),
    .data_o(rd_data_b_o)
  );
endmodule

// File: rtl/dwrf_checker.sv
module dwrf_checker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_addr_a_i,
  input logic [DATA_W-1:0] rd_data_a_o,
  input logic [ADDR_W-1:0] rd_addr_b_i,
  input logic [DATA_W-1:0] rd_data_b_o,
  input logic              wr_en_a_i,
  input logic [ADDR_W-1:0] wr_addr_a_i,
  input logic [DATA_W-1:0] wr_data_a_i,
  input logic              wr_en_b_i,
  input logic [ADDR_W-1:0] wr_addr_b_i,
  input logic [DATA_W-1:0] wr_data_b_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  a_r1_zero_read_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_a_i == '0 |-> rd_data_a_o == '0);
  a_r1_zero_read_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_b_i == '0 |-> rd_data_b_o == '0);

  // R3
  a_r3_port_a_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(wr_en_a_i) && $past(wr_addr_a_i) != '0 &&
    rd_addr_a_i == $past(wr_addr_a_i) |-> rd_data_a_o == $past(wr_data_a_i));

  // R4
  a_r4_port_b_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(wr_en_b_i) && $past(wr_addr_b_i) != '0 &&
    !($past(wr_en_a_i) && $past(wr_addr_a_i) == $past(wr_addr_b_i)) &&
    rd_addr_b_i == $past(wr_addr_b_i) |-> rd_data_b_o == $past(wr_data_b_i));

  // R5
  a_r5_both_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(wr_en_a_i) && $past(wr_en_b_i) &&
    $past(wr_addr_a_i) != '0 && $past(wr_addr_b_i) != '0 &&
    $past(wr_addr_a_i) != $past(wr_addr_b_i) &&
    rd_addr_a_i == $past(wr_addr_a_i) && rd_addr_b_i == $past(wr_addr_b_i)
    |-> rd_data_a_o == $past(wr_data_a_i) && rd_data_b_o == $past(wr_data_b_i));

  // R6
  a_r6_port_a_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(wr_en_a_i) && $past(wr_en_b_i) && $past(wr_addr_a_i) != '0 &&
    $past(wr_addr_a_i) == $past(wr_addr_b_i) && rd_addr_b_i == $past(wr_addr_a_i)
    |-> rd_data_b_o == $past(wr_data_a_i));

  // R7 and R9: untouched entry keeps its read value
  a_r7_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && rd_addr_a_i == $past(rd_addr_a_i) &&
    !($past(wr_en_a_i) && $past(wr_addr_a_i) == rd_addr_a_i) &&
    !($past(wr_en_b_i) && $past(wr_addr_b_i) == rd_addr_a_i)
    |-> rd_data_a_o == $past(rd_data_a_o));
  a_r7_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && rd_addr_b_i == $past(rd_addr_b_i) &&
    !($past(wr_en_a_i) && $past(wr_addr_a_i) == rd_addr_b_i) &&
    !($past(wr_en_b_i) && $past(wr_addr_b_i) == rd_addr_b_i)
    |-> rd_data_b_o == $past(rd_data_b_o));

  // R8
  a_r8_same_addr_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_a_i == rd_addr_b_i |-> rd_data_a_o == rd_data_b_o);
endmodule

bind dual_wr_regfile dwrf_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_addr_a_i(rd_addr_a_i),
  .rd_data_a_o(rd_data_a_o),
  .rd_addr_b_i(rd_addr_b_i),
  .rd_data_b_o(rd_data_b_o),
  .wr_en_a_i  (wr_en_a_i),
  .wr_addr_a_i(wr_addr_a_i),
  .wr_data_a_i(wr_data_a_i),
  .wr_en_b_i  (wr_en_b_i),
  .wr_addr_b_i(wr_addr_b_i),
  .wr_data_b_i(wr_data_b_i)
);

// File: tb/dual_wr_regfile_tb.sv
`timescale 1ns/1ps
module dual_wr_regfile_tb_top;
  localparam int NR = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ra, rb, wa_a, wa_b;
  logic [DW-1:0] rd_a, rd_b, wd_a, wd_b;
  logic          we_a, we_b;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] model [NR];

  always #2.5 clk = ~clk;

  dual_wr_regfile #(.NUM_REGS(NR), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_a_i(ra), .rd_data_a_o(rd_a),
    .rd_addr_b_i(rb), .rd_data_b_o(rd_b),
    .wr_en_a_i(we_a), .wr_addr_a_i(wa_a), .wr_data_a_i(wd_a),
    .wr_en_b_i(we_b), .wr_addr_b_i(wa_b), .wr_data_b_i(wd_b)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle: drive after negedge, compare reads, then model the edge
  task automatic cyc(input string tag,
                     input logic ea, input logic [AW-1:0] aa, input logic [DW-1:0] da,
                     input logic eb, input logic [AW-1:0] ab, input logic [DW-1:0] db,
                     input logic [AW-1:0] xa, input logic [AW-1:0] xb);
    we_a = ea; wa_a = aa; wd_a = da;
    we_b = eb; wa_b = ab; wd_b = db;
    ra = xa; rb = xb;
    #1;
    check({tag, " rdA"}, rd_a, model[xa]);
    check({tag, " rdB"}, rd_b, model[xb]);
    @(posedge clk);
    if (eb && ab != 0) model[ab] = db;
    if (ea && aa != 0) model[aa] = da;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NR; i++)
      cyc(tag, 1'b0, '0, '0, 1'b0, '0, '0, AW'(i), AW'(NR - 1 - i));
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    we_a = 0; we_b = 0; wa_a = 0; wa_b = 0; wd_a = 0; wd_b = 0; ra = 0; rb = 0;
    @(negedge clk);
    do_reset();
    read_all("R2 reset clear");

    // R3: port A alone fills every entry
    for (int i = 0; i < NR; i++)
      cyc("R3 port A fill", 1'b1, AW'(i), 32'hA000_0000 + 32'(i), 1'b0, '0, '0, AW'(i), AW'((i + 31) % NR));
    read_all("R3 port A readback");

    // R4: port B alone overwrites every entry
    for (int i = 0; i < NR; i++)
      cyc("R4 port B fill", 1'b0, '0, '0, 1'b1, AW'(i), 32'hB000_0000 + 32'(i), AW'((i + 31) % NR), AW'(i));
    read_all("R4 port B readback");

    // R5: both ports, distinct registers (post-increment style)
    for (int i = 1; i < NR - 1; i++)
      cyc("R5 dual commit", 1'b1, AW'(i), 32'h5A00_0000 + 32'(i), 1'b1, AW'(i + 1), 32'h5B00_0000 + 32'(i),
          AW'(i - 1), AW'(i));
    read_all("R5 dual readback");

    // R6: same address, port A wins
    cyc("R6 collide", 1'b1, 5'd9, 32'h0000_0046, 1'b1, 5'd9, 32'hDEAD_BEEF, 5'd9, 5'd9);
    cyc("R6 collide result", 1'b1, 5'd20, 32'h1111_2222, 1'b1, 5'd20, 32'h3333_4444, 5'd9, 5'd9);
    cyc("R6 collide result", 1'b0, '0, '0, 1'b0, '0, '0, 5'd20, 5'd20);

    // R1: writes to register 0 ignored
    cyc("R1 write zero", 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b1, 5'd0, 32'h1234_5678, 5'd0, 5'd0);
    cyc("R1 write zero B", 1'b0, '0, '0, 1'b1, 5'd0, 32'hCAFE_F00D, 5'd0, 5'd0);
    cyc("R1 zero after", 1'b0, '0, '0, 1'b0, '0, '0, 5'd0, 5'd0);

    // R9: disabled ports carry garbage
    for (int i = 0; i < 8; i++)
      cyc("R9 disabled", 1'b0, AW'(3 + i), 32'hBAD0_0000 + 32'(i), 1'b0, AW'(4 + i), 32'hBAD1_0000 + 32'(i),
          AW'(3 + i), AW'(4 + i));
    read_all("R9 disabled readback");

    // R7: read the register being written in the same cycle
    cyc("R7 old value", 1'b1, 5'd7, 32'h7777_0001, 1'b1, 5'd8, 32'h8888_0001, 5'd7, 5'd8);
    cyc("R7 new value", 1'b1, 5'd7, 32'h7777_0002, 1'b0, '0, '0, 5'd7, 5'd8);
    cyc("R7 new value", 1'b0, '0, '0, 1'b0, '0, '0, 5'd7, 5'd7);

    // R8: both read ports same and different addresses, mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a1, a2, r1, r2;
      logic [DW-1:0] d1, d2;
      a1 = AW'($urandom); a2 = ($urandom % 4 == 0) ? a1 : AW'($urandom);
      d1 = $urandom; d2 = $urandom;
      r1 = ($urandom % 3 == 0) ? a1 : AW'($urandom);
      r2 = ($urandom % 3 == 0) ? r1 : AW'($urandom);
      cyc("R8 mixed", 1'($urandom), a1, d1, 1'($urandom), a2, d2, r1, r2);
      if (n == 300) begin
        do_reset();
        read_all("R2 mid reset");
      end
    end
    read_all("R8 final readback");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule